// File: doc/BRIEF.md
# Shared Under-Load Timer and Supply Fault Manager

This block decides, every clock, which of a bank of switch drivers may actually conduct. It takes the commanded on/off state of every switch and removes from it the switches that protection has latched off, as well as all switches while a supply or thermal condition forbids driving. It also keeps three sticky status flags for the serial status word: under-load seen, supply failure seen and thermal warning seen.

All switches share one under-load delay counter. The counter advances on a time tick while at least one conducting switch reports too little load current. It returns to zero as soon as none does. When it reaches its limit, the under-load status is set. If the under-load shutdown command is set, every switch still reporting under-load at that moment is latched off. A switch that starts reporting after the counter has started waits only for the rest of that count. A status-reset pulse clears all flags and releases latched switches. Holding the enable input low clears everything and turns all switches off.

Top module: `fault_mgr`

## Requirements
- R1: During reset, and in every cycle after a cycle with `enable_i` low, all status outputs are 0, `drv_en_o` is 0 and all latched-off switches are released.
- R2: With no fault, `drv_en_o` equals `cmd_on_i` one clock later. A switch never conducts unless it was commanded in the previous cycle.
- R3: With `tick_i` high every cycle, under-load on a conducting switch sets `uld_st_o` on the clock after `UL_DELAY` (default 350) ticks and not earlier. The counter restarts from zero after any cycle in which no conducting switch reports under-load.
- R4: A switch whose under-load begins after another switch started the counter is handled when that same count expires, not after a fresh delay.
- R5: At expiry with `uld_cmd_i`=1, each switch reporting under-load is latched off and its bit of `drv_en_o` drops one clock after `uld_st_o` rises. With `uld_cmd_i`=0 the outputs are unchanged.
- R6: Undervoltage on any supply sets `psf_st_o` and forces `drv_en_o` to 0 on the next clock. The commanded state returns one clock after the condition clears, while `psf_st_o` stays set.
- R7: Overvoltage on any supply sets `psf_st_o`. It forces all outputs off only while `ovlo_cmd_i`=1, and the outputs return when it clears.
- R8: A thermal warning on any sensor sets `tw_st_o`, which stays set after the warning ends. Outputs are not affected.
- R9: Thermal shutdown on any sensor forces all outputs off on the next clock, with no status bit set. The outputs return one clock after it clears.
- R10: An `srr_i` pulse clears `uld_st_o`, `psf_st_o` and `tw_st_o` on the next clock and releases latched switches, which conduct again one clock later. A fault condition present in the same cycle sets its flag again (set wins).
- R11: The under-load counter advances only in cycles with `tick_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Device awake; low clears all state |
| cmd_on_i | input | NUM_SW | Commanded switch states, bit i = switch i |
| ul_flag_i | input | NUM_SW | Per-switch under-load comparator |
| uv_i | input | NUM_SUP | Per-supply undervoltage |
| ov_i | input | NUM_SUP | Per-supply overvoltage |
| tw_i | input | NUM_SENS | Per-sensor thermal warning |
| tsd_i | input | NUM_SENS | Per-sensor thermal shutdown |
| uld_cmd_i | input | 1 | 1 = under-load latches switches off |
| ovlo_cmd_i | input | 1 | 1 = overvoltage turns outputs off |
| srr_i | input | 1 | Status reset pulse |
| tick_i | input | 1 | Time-base tick for the under-load counter |
| uld_st_o | output | 1 | Sticky under-load status |
| psf_st_o | output | 1 | Sticky supply-fail status |
| tw_st_o | output | 1 | Sticky thermal-warning status |
| drv_en_o | output | NUM_SW | Final per-switch drive enable |

## Verification
The hardest case to reach is the shared-timer handoff. The counter must stay alive while one switch stops reporting under-load and another starts reporting in the very same cycle, so that the second switch latches at the first switch's deadline. The bench swaps the flag pattern at a single falling edge after a counted number of ticks, so the set of active switches never goes empty. It then checks the exact cycle of expiry against a fresh full delay. A second sequence puts exactly one empty cycle in the middle of a count to show the restart.

// File: rtl/fault_mgr_pkg.sv
package fault_mgr_pkg;
  localparam int unsigned DEF_NUM_SW   = 12;
  localparam int unsigned DEF_NUM_SENS = 6;
  localparam int unsigned DEF_NUM_SUP  = 2;
  localparam int unsigned DEF_UL_DELAY = 350;

  typedef enum logic [1:0] {
    ST_ULD = 2'd0,
    ST_PSF = 2'd1,
    ST_TW  = 2'd2
  } status_idx_e;

  localparam int unsigned NUM_STATUS = 3;
endpackage

// File: rtl/fm_sticky.sv
module fm_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  input  logic srr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= 1'b0;
    else if (clr_i) q_q <= 1'b0;
    else            q_q <= set_i | (q_q & ~srr_i);  // set wins over reset
  end

  assign q_o = q_q;
endmodule

// File: rtl/fm_ul_timer.sv
module fm_ul_timer #(
  parameter int unsigned NUM_SW   = 12,
  parameter int unsigned UL_DELAY = 350
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [NUM_SW-1:0] ul_act_i,
  input  logic              uld_cmd_i,
  input  logic              srr_i,
  output logic              hit_o,
  output logic [NUM_SW-1:0] latch_o
);
  localparam int unsigned CW = $clog2(UL_DELAY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(UL_DELAY);

  logic [CW-1:0]     cnt_q;
  logic [NUM_SW-1:0] latch_q;
  logic              any_act;
  logic              expired;

  assign any_act = |ul_act_i;
  assign expired = (cnt_q == LIMIT);
  assign hit_o   = expired & any_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || !any_act) cnt_q <= '0;
    else if (tick_i && !expired) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_SW; i++) begin : g_latch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    latch_q[i] <= 1'b0;
      else if (clr_i) latch_q[i] <= 1'b0;
      else            latch_q[i] <= (latch_q[i] & ~srr_i) |
                                    (hit_o & uld_cmd_i & ul_act_i[i]);
    end
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/fm_gate.sv
module fm_gate #(
  parameter int unsigned NUM_SW = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [NUM_SW-1:0] cmd_i,
  input  logic [NUM_SW-1:0] latch_i,
  input  logic              uv_any_i,
  input  logic              ov_any_i,
  input  logic              ovlo_cmd_i,
  input  logic              tsd_any_i,
  output logic [NUM_SW-1:0] drv_en_o
);
  logic              block_all;
  logic [NUM_SW-1:0] drv_en_q;

  assign block_all = ~enable_i | uv_any_i | (ov_any_i & ovlo_cmd_i) | tsd_any_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_en_q <= '0;
    else         drv_en_q <= block_all ? '0 : (cmd_i & ~latch_i);
  end

  assign drv_en_o = drv_en_q;
endmodule

// File: rtl/fault_mgr.sv
module fault_mgr
  import fault_mgr_pkg::*;
#(
  parameter int unsigned NUM_SW   = DEF_NUM_SW,
  parameter int unsigned NUM_SENS = DEF_NUM_SENS,
  parameter int unsigned NUM_SUP  = DEF_NUM_SUP,
  parameter int unsigned UL_DELAY = DEF_UL_DELAY
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic [NUM_SW-1:0]   cmd_on_i,
  input  logic [NUM_SW-1:0]   ul_flag_i,
  input  logic [NUM_SUP-1:0]  uv_i,
  input  logic [NUM_SUP-1:0]  ov_i,
  input  logic [NUM_SENS-1:0] tw_i,
  input  logic [NUM_SENS-1:0] tsd_i,
  input  logic                uld_cmd_i,
  input  logic                ovlo_cmd_i,
  input  logic                srr_i,
  input  logic                tick_i,
  output logic                uld_st_o,
  output logic                psf_st_o,
  output logic                tw_st_o,
  output logic [NUM_SW-1:0]   drv_en_o
);
  logic                  clr;
  logic                  ul_hit;
  logic [NUM_SW-1:0]     latch;
  logic [NUM_SW-1:0]     ul_act;
  logic [NUM_STATUS-1:0] st_set;
  logic [NUM_STATUS-1:0] st_q;
  logic                  uv_any, ov_any, tsd_any;

  assign clr     = ~enable_i;
  assign uv_any  = |uv_i;
  assign ov_any  = |ov_i;
  assign tsd_any = |tsd_i;
  // only conducting switches can be under-loaded
  assign ul_act  = ul_flag_i & drv_en_o;

  fm_ul_timer #(.NUM_SW(NUM_SW), .UL_DELAY(UL_DELAY)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .tick_i    (tick_i),
    .ul_act_i  (ul_act),
    .uld_cmd_i (uld_cmd_i),
    .srr_i     (srr_i),
    .hit_o     (ul_hit),
    .latch_o   (latch)
  );

  assign st_set[ST_ULD] = ul_hit;
  assign st_set[ST_PSF] = uv_any | ov_any;
  assign st_set[ST_TW]  = |tw_i;

  for (genvar s = 0; s < NUM_STATUS; s++) begin : g_status
    fm_sticky u_sticky (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .set_i  (st_set[s]),
      .srr_i  (srr_i),
      .q_o    (st_q[s])
    );
  end

  assign uld_st_o = st_q[ST_ULD];
  assign psf_st_o = st_q[ST_PSF];
  assign tw_st_o  = st_q[ST_TW];

  fm_gate #(.NUM_SW(NUM_SW)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .cmd_i      (cmd_on_i),
    .latch_i    (latch),
    .uv_any_i   (uv_any),
    .ov_any_i   (ov_any),
    .ovlo_cmd_i (ovlo_cmd_i),
    .tsd_any_i  (tsd_any),
    .drv_en_o   (drv_en_o)
  );
endmodule

// File: rtl/fault_mgr_chk.sv
module fault_mgr_chk #(
  parameter int unsigned NUM_SW   = 12,
  parameter int unsigned NUM_SENS = 6,
  parameter int unsigned NUM_SUP  = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                enable_i,
  input logic [NUM_SW-1:0]   cmd_on_i,
  input logic [NUM_SUP-1:0]  uv_i,
  input logic [NUM_SUP-1:0]  ov_i,
  input logic [NUM_SENS-1:0] tw_i,
  input logic [NUM_SENS-1:0] tsd_i,
  input logic                srr_i,
  input logic                uld_st_o,
  input logic                psf_st_o,
  input logic                tw_st_o,
  input logic [NUM_SW-1:0]   drv_en_o
);
  p_sleep_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (drv_en_o == '0) && !uld_st_o && !psf_st_o && !tw_st_o);

  p_only_commanded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((drv_en_o & ~$past(cmd_on_i)) == '0));

  p_uv_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && (|uv_i) |=> (drv_en_o == '0) && psf_st_o);

  p_ov_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && (|ov_i) |=> psf_st_o);

  p_tw_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && tw_st_o && !srr_i |=> tw_st_o);

  p_tsd_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tsd_i) |=> (drv_en_o == '0));

  p_srr_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srr_i && !(|uv_i) && !(|ov_i) && !(|tw_i) |=> !psf_st_o && !tw_st_o);
endmodule

bind fault_mgr fault_mgr_chk #(
  .NUM_SW(NUM_SW), .NUM_SENS(NUM_SENS), .NUM_SUP(NUM_SUP)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .cmd_on_i (cmd_on_i),
  .uv_i     (uv_i),
  .ov_i     (ov_i),
  .tw_i     (tw_i),
  .tsd_i    (tsd_i),
  .srr_i    (srr_i),
  .uld_st_o (uld_st_o),
  .psf_st_o (psf_st_o),
  .tw_st_o  (tw_st_o),
  .drv_en_o (drv_en_o)
);

// File: tb/fault_mgr_test.sv
module fault_mgr_test;
  localparam int unsigned NSW = 12;
  localparam int unsigned DLY = 350;
  localparam logic [11:0] ALL = 12'hFFF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic [11:0] cmd_on_i = '0;
  logic [11:0] ul_flag_i = '0;
  logic [1:0]  uv_i = '0, ov_i = '0;
  logic [5:0]  tw_i = '0, tsd_i = '0;
  logic        uld_cmd_i = 1'b0, ovlo_cmd_i = 1'b0, srr_i = 1'b0, tick_i = 1'b1;
  logic        uld_st_o, psf_st_o, tw_st_o;
  logic [11:0] drv_en_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  fault_mgr uut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .cmd_on_i(cmd_on_i),
    .ul_flag_i(ul_flag_i), .uv_i(uv_i), .ov_i(ov_i), .tw_i(tw_i), .tsd_i(tsd_i),
    .uld_cmd_i(uld_cmd_i), .ovlo_cmd_i(ovlo_cmd_i), .srr_i(srr_i), .tick_i(tick_i),
    .uld_st_o(uld_st_o), .psf_st_o(psf_st_o), .tw_st_o(tw_st_o), .drv_en_o(drv_en_o)
  );

  task automatic chk(input string what, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_srr();
    srr_i = 1'b1; cyc(1); srr_i = 1'b0;
  endtask

  task automatic t_reset();
    cyc(2);
    chk("R1 reset drv_en", drv_en_o, '0);
    chk("R1 reset status", {9'b0, uld_st_o, psf_st_o, tw_st_o}, '0);
    rst_ni = 1'b1; enable_i = 1'b1; cyc(1);
  endtask

  task automatic t_cmd();
    cmd_on_i = 12'h0A5; cyc(1);
    chk("R2 follow 0A5", drv_en_o, 12'h0A5);
    cmd_on_i = 12'hF3C; cyc(1);
    chk("R2 follow F3C", drv_en_o, 12'hF3C);
    cmd_on_i = ALL; cyc(1);
    chk("R2 follow FFF", drv_en_o, ALL);
  endtask

  task automatic t_ul_latch();
    uld_cmd_i = 1'b1; ul_flag_i = 12'h001;
    cyc(DLY);
    chk("R3 uld not early", {11'b0, uld_st_o}, 12'h0);
    cyc(1);
    chk("R3 uld at expiry", {11'b0, uld_st_o}, 12'h1);
    chk("R5 drv still on at expiry", drv_en_o, ALL);
    cyc(1);
    chk("R5 switch 0 latched", drv_en_o, 12'hFFE);
    ul_flag_i = '0; cyc(1);
    pulse_srr();
    chk("R10 uld cleared", {11'b0, uld_st_o}, 12'h0);
    chk("R10 latch still visible", drv_en_o, 12'hFFE);
    cyc(1);
    chk("R10 switch released", drv_en_o, ALL);
  endtask

  task automatic t_ul_shared();
    uld_cmd_i = 1'b1; ul_flag_i = 12'h001;
    cyc(100);
    ul_flag_i = 12'h002;
    cyc(DLY - 100);
    chk("R4 uld not early", {11'b0, uld_st_o}, 12'h0);
    cyc(1);
    chk("R4 uld at shared expiry", {11'b0, uld_st_o}, 12'h1);
    cyc(1);
    chk("R4 late switch latched on remainder", drv_en_o, 12'hFFD);
    ul_flag_i = '0; cyc(1); pulse_srr(); cyc(1);
    chk("R10 after shared", drv_en_o, ALL);
  endtask

  task automatic t_ul_nolatch();
    uld_cmd_i = 1'b0; ul_flag_i = 12'h004;
    cyc(DLY + 1);
    chk("R5 uld set w/o latch", {11'b0, uld_st_o}, 12'h1);
    cyc(3);
    chk("R5 outputs unchanged", drv_en_o, ALL);
    ul_flag_i = '0; cyc(1); pulse_srr();
    chk("R10 uld cleared", {11'b0, uld_st_o}, 12'h0);
  endtask

  task automatic t_ul_restart();
    uld_cmd_i = 1'b0; ul_flag_i = 12'h010;
    cyc(200);
    ul_flag_i = '0; cyc(1);
    ul_flag_i = 12'h010;
    cyc(DLY - 50);
    chk("R3 restart no early set", {11'b0, uld_st_o}, 12'h0);
    cyc(51);
    chk("R3 set after full delay", {11'b0, uld_st_o}, 12'h1);
    ul_flag_i = '0; cyc(1); pulse_srr();
  endtask

  task automatic t_tick();
    uld_cmd_i = 1'b0; tick_i = 1'b0; ul_flag_i = 12'h008;
    cyc(DLY + 50);
    chk("R11 no ticks no expiry", {11'b0, uld_st_o}, 12'h0);
    tick_i = 1'b1;
    cyc(DLY + 1);
    chk("R11 expiry counts ticks only", {11'b0, uld_st_o}, 12'h1);
    ul_flag_i = '0; cyc(1); pulse_srr();
  endtask

  task automatic t_uv();
    uv_i = 2'b01; cyc(1);
    chk("R6 uv off", drv_en_o, '0);
    chk("R6 psf set", {11'b0, psf_st_o}, 12'h1);
    uv_i = 2'b00; cyc(1);
    chk("R6 outputs back", drv_en_o, ALL);
    chk("R6 psf sticky", {11'b0, psf_st_o}, 12'h1);
    pulse_srr();
    chk("R10 psf cleared", {11'b0, psf_st_o}, 12'h0);
    uv_i = 2'b10; srr_i = 1'b1; cyc(1); srr_i = 1'b0; uv_i = '0;
    chk("R10 set wins", {11'b0, psf_st_o}, 12'h1);
    cyc(1); pulse_srr();
  endtask

  task automatic t_ov();
    ovlo_cmd_i = 1'b0; ov_i = 2'b10; cyc(1);
    chk("R7 psf set", {11'b0, psf_st_o}, 12'h1);
    chk("R7 no gate w/o ovlo", drv_en_o, ALL);
    ovlo_cmd_i = 1'b1; cyc(1);
    chk("R7 gate with ovlo", drv_en_o, '0);
    ov_i = '0; cyc(1);
    chk("R7 outputs back", drv_en_o, ALL);
    pulse_srr(); ovlo_cmd_i = 1'b0;
    chk("R10 psf cleared", {11'b0, psf_st_o}, 12'h0);
  endtask

  task automatic t_tw();
    tw_i = 6'b100000; cyc(1);
    chk("R8 tw set", {11'b0, tw_st_o}, 12'h1);
    chk("R8 outputs stay", drv_en_o, ALL);
    tw_i = '0; cyc(2);
    chk("R8 tw sticky", {11'b0, tw_st_o}, 12'h1);
    pulse_srr();
    chk("R10 tw cleared", {11'b0, tw_st_o}, 12'h0);
  endtask

  task automatic t_tsd();
    tsd_i = 6'b001000; cyc(1);
    chk("R9 tsd all off", drv_en_o, '0);
    chk("R9 no status", {9'b0, uld_st_o, psf_st_o, tw_st_o}, '0);
    tsd_i = '0; cyc(1);
    chk("R9 outputs back", drv_en_o, ALL);
  endtask

  task automatic t_sleep();
    uld_cmd_i = 1'b1; ul_flag_i = 12'h020;
    cyc(DLY + 2);
    chk("R5 switch 5 latched", drv_en_o, 12'hFDF);
    ul_flag_i = '0; uv_i = 2'b01; cyc(1); uv_i = '0;
    enable_i = 1'b0; cyc(1);
    chk("R1 sleep drv off", drv_en_o, '0);
    chk("R1 sleep status clear", {9'b0, uld_st_o, psf_st_o, tw_st_o}, '0);
    enable_i = 1'b1; cyc(1);
    chk("R1 latch released by sleep", drv_en_o, ALL);
  endtask

  initial begin
    t_reset();
    t_cmd();
    t_ul_latch();
    t_ul_shared();
    t_ul_nolatch();
    t_ul_restart();
    t_tick();
    t_uv();
    t_ov();
    t_tw();
    t_tsd();
    t_sleep();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule